// File: doc/BRIEF.md
# Multichannel Conversion Scan Sequencer

This block schedules conversions of a 12-bit analog converter across eight input channels. The channel set comes from an 8-bit enable mask. The sequencer runs only when the start control is high and the conversion-mode field selects autonomous operation. While it runs, it visits the enabled channels in ascending order and issues one conversion request per channel. It waits for the converter to answer with a done pulse and a result, then stores that result in the channel's result byte pair. At the end of a scan an interval timer counts a programmable number of timebase ticks, and then the next scan begins.

The converter is outside the block, reached through a request/done handshake with a channel index and a 12-bit result. The timebase arrives as a tick-enable input. One tick per microsecond gives the nominal spacing: 750 ticks between scans at interval code 0. A faster tick, or a smaller `BASE_TICKS`, shortens that spacing for simulation. Stored results are read one byte at a time through a combinational byte-address port.

The enable mask is copied into an internal working mask only while the start control is low. Software therefore has to stop and restart the sequencer for a new channel list to take effect.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `convReq` is low and every result byte reads 0.
- R2: Conversion requests are issued only while `cfgStart` is 1 and `cfgConvMode` is 1 (autonomous). Mode 0 (manual), or any other mode value, issues no request. A conversion already in flight completes and is stored, and the sequencer then idles.
- R3: Within a scan, `cfgSeqMode` = 1 requests every channel whose working-mask bit is set, in ascending index order. Channels whose bit is clear get no request.
- R4: The working mask follows `cfgChanMask` only in cycles where `cfgStart` is 0. Mask changes made while started have no effect until a stop and a restart.
- R5: When the working mask is empty, starting issues no request and the interval timer never runs.
- R6: A scan's first request comes in the cycle after the edge at which the interval timer expires. The timer starts counting at the edge that stores the previous scan's last result. It expires on the Nth `tickEn` edge after that edge, where N = `BASE_TICKS` << `cfgIntervalSel`. Code 0 gives `BASE_TICKS`, which is 750 by default.
- R7: Channel c's result sits in two bytes. Byte address 2c holds result bits [3:0] in bits [7:4], with zeros in bits [3:0]. Byte address 2c+1 holds result bits [11:4].
- R8: A result is written only when `cfgStatsEn` is 1 in the cycle `convDone` arrives. Otherwise the stored bytes keep their values.
- R9: With `cfgSeqMode` other than 1, each scan requests only the lowest-indexed enabled channel.
- R10: `convReq` is a one-cycle pulse, and no new request is issued until `convDone` returns. A `convDone` with no conversion outstanding changes nothing. The converter must answer within `CONV_TICKS` (6) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgStart | input | 1 | Run (1) or halt (0) the sequencer |
| cfgConvMode | input | 2 | Conversion mode: 0 manual, 1 autonomous |
| cfgSeqMode | input | 2 | 1 walks all enabled channels; other values take the lowest only |
| cfgIntervalSel | input | 2 | Scan spacing code, N = BASE_TICKS << code |
| cfgStatsEn | input | 1 | Permit result storage |
| cfgChanMask | input | 8 | Channel enable mask, bit c for channel c |
| tickEn | input | 1 | Interval timebase tick |
| convReq | output | 1 | One-cycle conversion request |
| convChan | output | 3 | Channel of the current conversion |
| convDone | input | 1 | Converter result valid pulse |
| convData | input | 12 | Converter result |
| rdAddr | input | 4 | Result byte address (2c or 2c+1) |
| rdData | output | 8 | Result byte at rdAddr |

## Verification
A corrupted scan pointer or state register shows up at `convReq`/`convChan` in the very next cycle. It appears as a request for a masked-off channel, a skipped channel, an out-of-order index, or a request while stopped. A wrong interval count moves the first request of the next scan away from its expected cycle. That shows within one interval, at most 6000 ticks at the default base. Wrong result steering or nibble packing appears on `rdData` as soon as the byte sweep reaches the affected address, within 16 cycles of the store.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int RES_W = 12;
  localparam logic [1:0] MODE_AUTO = 2'd1;
  localparam logic [1:0] SEQ_WALK  = 2'd1;

  typedef struct packed {
    logic latchFirst;  // load scan pointer with lowest enabled channel
    logic latchNext;   // advance scan pointer to next enabled channel
    logic storeRes;    // capture converter result for current channel
    logic clrTimer;    // restart interval count
    logic timerRun;    // interval count may advance
  } scanStrobe_t;

endpackage

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int BASE_TICKS = 750,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int TMR_W     = $clog2(BASE_TICKS * 8)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgStart,
  input  logic [NUM_CH-1:0]       cfgChanMask,
  input  logic [1:0]              cfgIntervalSel,
  input  logic [1:0]              cfgSeqMode,
  input  logic                    cfgStatsEn,
  input  logic                    tickEn,
  input  scanStrobe_t             strobe,
  input  logic [RES_W-1:0]        convData,
  input  logic [CH_W:0]           rdAddr,
  output logic [7:0]              rdData,
  output logic [CH_W-1:0]         curCh,
  output logic                    maskNz,
  output logic                    hasNext,
  output logic                    timerDone,
  output logic [NUM_CH-1:0]       latchedMask,
  output logic [NUM_CH*RES_W-1:0] resFlat
);

  logic [CH_W-1:0]  firstCh;
  logic [CH_W-1:0]  nextCh;
  logic             nextFound;
  logic [TMR_W-1:0] timerCnt;
  logic [TMR_W-1:0] period;
  logic [RES_W-1:0] resReg [NUM_CH];
  logic [CH_W-1:0]  rdCh;

  // working mask copies the programmed mask only while halted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          latchedMask <= '0;
    else if (!cfgStart) latchedMask <= cfgChanMask;
  end

  assign maskNz = |latchedMask;

  // lowest enabled channel, and lowest enabled channel above the pointer
  always_comb begin
    firstCh   = '0;
    nextCh    = '0;
    nextFound = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (latchedMask[i]) firstCh = CH_W'(i);
      if (latchedMask[i] && (CH_W'(i) > curCh)) begin
        nextCh    = CH_W'(i);
        nextFound = 1'b1;
      end
    end
  end

  assign hasNext = nextFound && (cfgSeqMode == SEQ_WALK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  curCh <= '0;
    else if (strobe.latchFirst) curCh <= firstCh;
    else if (strobe.latchNext)  curCh <= nextCh;
  end

  // interval timer, counts timebase ticks only while waiting
  assign period    = TMR_W'(BASE_TICKS) << cfgIntervalSel;
  assign timerDone = strobe.timerRun && tickEn && (timerCnt == period - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          timerCnt <= '0;
    else if (strobe.clrTimer)           timerCnt <= '0;
    else if (strobe.timerRun && tickEn) timerCnt <= timerCnt + 1'b1;
  end

  // per-channel result storage
  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gRes
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          resReg[g] <= '0;
        else if (strobe.storeRes && cfgStatsEn && (curCh == CH_W'(g)))
          resReg[g] <= convData;
      end
      assign resFlat[g*RES_W +: RES_W] = resReg[g];
    end
  endgenerate

  // split-nibble byte view
  assign rdCh = rdAddr[CH_W:1];

  always_comb begin
    if (rdAddr[0]) rdData = resReg[rdCh][11:4];
    else           rdData = {resReg[rdCh][3:0], 4'b0000};
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgStart,
  input  logic [1:0]  cfgConvMode,
  input  logic        maskNz,
  input  logic        hasNext,
  input  logic        timerDone,
  input  logic        convDone,
  output logic        convReq,
  output scanStrobe_t strobe
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_BUSY, S_WAIT} scanState_e;

  scanState_e state, stateNxt;
  logic       running;

  assign running = cfgStart && (cfgConvMode == MODE_AUTO) && maskNz;
  assign convReq = (state == S_REQ);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      S_IDLE: begin
        if (running) begin
          strobe.latchFirst = 1'b1;
          stateNxt          = S_REQ;
        end
      end
      S_REQ: stateNxt = S_BUSY;
      S_BUSY: begin
        if (convDone) begin
          strobe.storeRes = 1'b1;
          if (running && hasNext) begin
            strobe.latchNext = 1'b1;
            stateNxt         = S_REQ;
          end else if (running) begin
            strobe.clrTimer = 1'b1;
            stateNxt        = S_WAIT;
          end else begin
            stateNxt = S_IDLE;
          end
        end
      end
      S_WAIT: begin
        strobe.timerRun = 1'b1;
        if (!running) begin
          stateNxt = S_IDLE;
        end else if (timerDone) begin
          strobe.latchFirst = 1'b1;
          stateNxt          = S_REQ;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int BASE_TICKS = 750,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStart,
  input  logic [1:0]        cfgConvMode,
  input  logic [1:0]        cfgSeqMode,
  input  logic [1:0]        cfgIntervalSel,
  input  logic              cfgStatsEn,
  input  logic [NUM_CH-1:0] cfgChanMask,
  input  logic              tickEn,
  output logic              convReq,
  output logic [CH_W-1:0]   convChan,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  input  logic [CH_W:0]     rdAddr,
  output logic [7:0]        rdData
);

  scanStrobe_t              strobe;
  logic                     maskNz;
  logic                     hasNext;
  logic                     timerDone;
  logic [NUM_CH-1:0]        latchedMask;
  logic [NUM_CH*RES_W-1:0]  resFlat;

  adc_scan_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgStart   (cfgStart),
    .cfgConvMode(cfgConvMode),
    .maskNz     (maskNz),
    .hasNext    (hasNext),
    .timerDone  (timerDone),
    .convDone   (convDone),
    .convReq    (convReq),
    .strobe     (strobe)
  );

  adc_scan_dp #(
    .NUM_CH    (NUM_CH),
    .BASE_TICKS(BASE_TICKS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cfgStart      (cfgStart),
    .cfgChanMask   (cfgChanMask),
    .cfgIntervalSel(cfgIntervalSel),
    .cfgSeqMode    (cfgSeqMode),
    .cfgStatsEn    (cfgStatsEn),
    .tickEn        (tickEn),
    .strobe        (strobe),
    .convData      (convData),
    .rdAddr        (rdAddr),
    .rdData        (rdData),
    .curCh         (convChan),
    .maskNz        (maskNz),
    .hasNext       (hasNext),
    .timerDone     (timerDone),
    .latchedMask   (latchedMask),
    .resFlat       (resFlat)
  );

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NUM_CH     = 8,
  parameter int CH_W       = 3,
  parameter int RES_W      = 12,
  parameter int CONV_TICKS = 6
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cfgStart,
  input logic [1:0]              cfgConvMode,
  input logic                    cfgStatsEn,
  input logic [NUM_CH-1:0]       cfgChanMask,
  input logic                    tickEn,
  input logic                    convReq,
  input logic [CH_W-1:0]         convChan,
  input logic                    convDone,
  input logic [NUM_CH-1:0]       latchedMask,
  input logic [NUM_CH*RES_W-1:0] resFlat
);

  logic       outstanding;
  logic [3:0] convAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      convAge     <= '0;
    end else if (convReq) begin
      outstanding <= 1'b1;
      convAge     <= '0;
    end else if (convDone) begin
      outstanding <= 1'b0;
    end else if (outstanding && tickEn && convAge != 4'hF) begin
      convAge <= convAge + 1'b1;
    end
  end

  assert_run_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgStart || cfgConvMode != 2'd1) |=> !convReq);

  assert_req_in_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> latchedMask[convChan]);

  assert_mask_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgStart |=> (latchedMask == $past(cfgChanMask)));

  assert_empty_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (latchedMask == '0) |-> !convReq);

  assert_stats_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgStatsEn |=> $stable(resFlat));

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq);

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outstanding && !convDone) |=> !convReq);

  assert_conv_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> (convAge <= 4'(CONV_TICKS)));

endmodule

bind adc_scan_seq adc_scan_chk #(
  .NUM_CH(NUM_CH),
  .CH_W  (CH_W),
  .RES_W (adc_scan_pkg::RES_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgStart   (cfgStart),
  .cfgConvMode(cfgConvMode),
  .cfgStatsEn (cfgStatsEn),
  .cfgChanMask(cfgChanMask),
  .tickEn     (tickEn),
  .convReq    (convReq),
  .convChan   (convChan),
  .convDone   (convDone),
  .latchedMask(latchedMask),
  .resFlat    (resFlat)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;

  localparam int BASE = 750;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgStart = 1'b0;
  logic [1:0]  cfgConvMode = 2'd0;
  logic [1:0]  cfgSeqMode = 2'd1;
  logic [1:0]  cfgIntervalSel = 2'd0;
  logic        cfgStatsEn = 1'b1;
  logic [7:0]  cfgChanMask = 8'h00;
  logic        tickEn = 1'b1;
  logic        convReq;
  logic [2:0]  convChan;
  logic        convDone = 1'b0;
  logic [11:0] convData = 12'h000;
  logic [3:0]  rdAddr = 4'd0;
  logic [7:0]  rdData;

  adc_scan_seq dut (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgConvMode(cfgConvMode),
    .cfgSeqMode(cfgSeqMode), .cfgIntervalSel(cfgIntervalSel),
    .cfgStatsEn(cfgStatsEn), .cfgChanMask(cfgChanMask), .tickEn(tickEn),
    .convReq(convReq), .convChan(convChan), .convDone(convDone),
    .convData(convData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #2 clk = ~clk;

  int    nVec = 0;
  int    nFail = 0;
  string tag = "R1";
  bit    finished = 0;

  // bench controls
  bit        sweepOn = 1;
  logic [3:0] rdSel = 4'd0;
  bit        forceDone = 0;
  bit        tickHalf = 0;
  bit        fixedOn = 0;
  int        busyCnt = 0;
  logic [11:0] pendData = 12'h0;
  int        reqCount = 0;
  int        reqSeen = 0;

  // behavioural reference: 0 idle, 1 request, 2 busy, 3 waiting
  int        mst = 0;
  int        mch = 0;
  int        mtimer = 0;
  logic [7:0] mmask = 8'h00;
  int        mres [8];

  function automatic int lowestCh(logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int nextCh(logic [7:0] m, int c);
    for (int i = c + 1; i < 8; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial for (int i = 0; i < 8; i++) mres[i] = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mst = 0; mch = 0; mtimer = 0; mmask = 8'h00;
      for (int i = 0; i < 8; i++) mres[i] = 0;
    end else begin
      bit run;
      int nx;
      run = cfgStart && (cfgConvMode == 2'd1) && (mmask != 0);
      case (mst)
        0: if (run) begin mst = 1; mch = lowestCh(mmask); end
        1: mst = 2;
        2: if (convDone) begin
             if (cfgStatsEn) mres[mch] = convData;
             nx = (cfgSeqMode == 2'd1) ? nextCh(mmask, mch) : -1;
             if (run && nx >= 0) begin mst = 1; mch = nx; end
             else if (run) begin mst = 3; mtimer = 0; end
             else mst = 0;
           end
        default: begin
          if (!run) mst = 0;
          else if (tickEn) begin
            if (mtimer == (BASE << cfgIntervalSel) - 1) begin
              mst = 1; mch = lowestCh(mmask);
            end else mtimer++;
          end
        end
      endcase
      if (!cfgStart) mmask = cfgChanMask;
    end
  end

  // compare every cycle, then drive the converter model and read address
  always @(negedge clk) begin
    int c;
    int expByte;
    if (!finished) begin
      chk(convReq == (mst == 1), "convReq", int'(convReq), int'(mst == 1));
      if (mst == 1) chk(int'(convChan) == mch, "convChan", int'(convChan), mch);
      c = int'(rdAddr) >> 1;
      expByte = rdAddr[0] ? ((mres[c] >> 4) & 8'hFF) : ((mres[c] & 4'hF) << 4);
      chk(int'(rdData) == expByte, "rdData", int'(rdData), expByte);
    end
    if (convReq) reqSeen++;
    rdAddr = sweepOn ? rdAddr + 4'd1 : rdSel;
    tickEn = tickHalf ? ~tickEn : 1'b1;
    convDone = 1'b0;
    if (busyCnt > 0) begin
      busyCnt--;
      if (busyCnt == 0) begin convDone = 1'b1; convData = pendData; end
    end else if (forceDone) begin
      convDone = 1'b1; convData = 12'hFFF;
    end
    if (convReq) begin
      busyCnt = 3;
      pendData = fixedOn ? 12'hABC : 12'((int'(convChan) * 12'h123 + reqCount * 5) & 12'hFFF);
      reqCount++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    cyc(6);
    chk(convReq == 1'b0, "convReq in reset", int'(convReq), 0);
    rstN = 1'b1;
    cyc(20);

    // R2: manual mode issues nothing
    tag = "R2";
    cfgChanMask = 8'hFF; cfgConvMode = 2'd0; cyc(2);
    cfgStart = 1'b1; reqSeen = 0; cyc(1000);
    chk(reqSeen == 0, "requests in manual mode", reqSeen, 0);
    cfgStart = 1'b0; cyc(4);

    // R3: ascending walk skipping cleared channels
    tag = "R3";
    cfgChanMask = 8'hA6; cfgConvMode = 2'd1; cyc(2);
    cfgStart = 1'b1; reqSeen = 0; cyc(2500);
    chk(reqSeen >= 12, "requests over three scans", reqSeen, 12);

    // R4: mask change while running is ignored until restart
    tag = "R4";
    cfgChanMask = 8'h01; cyc(1600);
    cfgStart = 1'b0; cyc(10);
    cfgStart = 1'b1; cyc(1600);

    // R5: empty mask
    tag = "R5";
    cfgStart = 1'b0; cyc(10);
    cfgChanMask = 8'h00; cyc(2);
    cfgStart = 1'b1; reqSeen = 0; cyc(1600);
    chk(reqSeen == 0, "requests with empty mask", reqSeen, 0);

    // R9: lowest channel only
    tag = "R9";
    cfgStart = 1'b0; cfgChanMask = 8'h30; cfgSeqMode = 2'd0; cyc(2);
    cfgStart = 1'b1; cyc(1600);
    cfgStart = 1'b0; cfgSeqMode = 2'd1; cyc(10);

    // R8: storage disabled
    tag = "R8";
    cfgStatsEn = 1'b0; cfgChanMask = 8'hFF; cyc(2);
    cfgStart = 1'b1; cyc(1600);
    cfgStatsEn = 1'b1;

    // R10: spurious done pulses
    tag = "R10";
    forceDone = 1; cyc(200); forceDone = 0; cyc(1600);

    // R6: interval codes and slower timebase
    tag = "R6";
    cfgIntervalSel = 2'd2; cyc(7000);
    cfgIntervalSel = 2'd0; tickHalf = 1; cyc(4000);
    tickHalf = 0; cyc(10);

    // R7: byte layout with a known result
    tag = "R7";
    cfgStart = 1'b0; cyc(10);
    fixedOn = 1; cfgChanMask = 8'h04; cyc(2);
    cfgStart = 1'b1; cyc(40);
    cfgStart = 1'b0; cyc(10);
    sweepOn = 0; rdSel = 4'd4; cyc(2);
    chk(rdData == 8'hC0, "byte 2c of channel 2", int'(rdData), 8'hC0);
    rdSel = 4'd5; cyc(2);
    chk(rdData == 8'hAB, "byte 2c+1 of channel 2", int'(rdData), 8'hAB);
    sweepOn = 1; cyc(20);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL %s watchdog expired actual=%0d expected=%0d", tag, 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

endmodule